// File: doc/BRIEF.md
# Routed SPI Master with Register Interface

This block is a byte-wide SPI master that a small processor controls through three registers on an 8-bit register bus. One register holds the exchange byte, one selects where the SPI lines go, and one sets the serial clock rate. Writing a byte to the exchange register shifts it out MSB first. At the same time a byte is shifted in from the selected slave. That byte then replaces the written one in the same register, because there is only one buffer.

The three serial lines can go to one of two endpoints: a set of general-purpose port pins or an internal peripheral port. The interface can also be switched off. The serial clock comes from the system clock through a power-of-two divider. The block has no slave-select output. Software drives slave selects from ordinary pins.

Top module: `spi_route_master`

## Requirements
- R1: After reset, the exchange register (address 0xB2), the routing register (0xB3) and the divider register (0xB4) all read 0x00. Both endpoints show SCK and MOSI low.
- R2: Bits [1:0] of the routing register and bits [3:0] of the divider register read back what was written. The unused bits read zero, except routing-register bit 6 (busy) and bit 7 (done).
- R3: With routing code 01, a write to the exchange register runs one 8-bit full-duplex exchange on the port endpoint. The exchange uses SPI mode 0: SCK idles low, MOSI is MSB first and changes only on falling SCK, and the slave's bits are sampled on rising SCK. Afterwards the exchange register reads the received byte.
- R4: With routing code 10, the exchange runs on the peripheral endpoint. The endpoint that is not selected keeps SCK and MOSI low, and its MISO input has no effect on the received byte.
- R5: With routing code 00 or 11, a write to the exchange register produces no SCK on either endpoint and does not set busy. The written byte reads back unchanged.
- R6: Divider code c sets the SCK half-period to h system clocks: h=1 for c=0 and c=1, h=2^(c-1) for c=2 to 6, and h=32 for every c above 6. One exchange keeps busy high for exactly 16*h clocks.
- R7: Busy (routing-register bit 6) is high during an exchange. Done (bit 7) goes high in the same clock in which busy falls after the eighth bit. Done is cleared by the next write to the exchange register.
- R8: A write to the exchange register while busy is ignored. Neither the bits sent nor the received byte change.
- R9: A divider write during an exchange takes effect from the next exchange. The exchange in progress keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data (combinational on busAddr) |
| portSck | output | 1 | Serial clock to port pins |
| portMosi | output | 1 | Serial data out to port pins |
| portMiso | input | 1 | Serial data in from port pins |
| perSck | output | 1 | Serial clock to peripheral port |
| perMosi | output | 1 | Serial data out to peripheral port |
| perMiso | input | 1 | Serial data in from peripheral port |

## Verification
A bad bit counter or a bad half-period latch shows up in the busy length. Busy would last a different number of clocks from 16*h, and done would rise at the wrong moment. Both are visible within a single exchange of at most 512 clocks. A wrong routing decode shows up within the first SCK half-period. Clock or data would appear on the unselected endpoint, or the received byte would take the constant level driven on the unselected MISO. A shift or sample edge that is off by one half-period corrupts the byte captured by the bench slave model, the byte read back, or both, as soon as the exchange ends.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;
  localparam logic [1:0] ROUTE_OFF    = 2'b00;
  localparam logic [1:0] ROUTE_PORT   = 2'b01;
  localparam logic [1:0] ROUTE_PERIPH = 2'b10;

  typedef struct packed {
    logic load;   // capture bus byte into shift register
    logic rise;   // SCK rising: sample MISO
    logic fall;   // SCK falling: shift
  } strobe_t;
endpackage

// File: rtl/spi_route_ctrl.sv
module spi_route_ctrl
  import spi_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'hB2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hB3,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 8'hB4,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 4,
  parameter int MAX_EXP = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output strobe_t           stb,
  output logic              sckOut,
  output logic              busy,
  output logic              done,
  output logic [1:0]        route,
  output logic [DIV_W-1:0]  divCode
);
  localparam int CNT_W = MAX_EXP;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  function automatic logic [CNT_W-1:0] halfFor(input logic [DIV_W-1:0] code);
    int e;
    if (int'(code) <= 1) e = 1;
    else if (int'(code) > MAX_EXP) e = MAX_EXP;
    else e = int'(code);
    return CNT_W'(1) << (e - 1);
  endfunction

  logic [CNT_W-1:0] halfQ, cnt;
  logic [BIT_W-1:0] bitCnt;
  logic dataWr, routeActive, start, tick, lastFall;

  always_comb begin
    dataWr      = busWrEn && (busAddr == DATA_ADDR);
    routeActive = (route == ROUTE_PORT) || (route == ROUTE_PERIPH);
    start       = dataWr && !busy && routeActive;
    tick        = busy && (cnt == halfQ - CNT_W'(1));
    stb.load    = dataWr && !busy;
    stb.rise    = tick && !sckOut;
    stb.fall    = tick && sckOut;
    lastFall    = stb.fall && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      route   <= ROUTE_OFF;
      divCode <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sckOut  <= 1'b0;
      halfQ   <= CNT_W'(1);
      cnt     <= '0;
      bitCnt  <= '0;
    end else begin
      if (busWrEn && busAddr == CTRL_ADDR) route   <= busWrData[1:0];
      if (busWrEn && busAddr == DIV_ADDR)  divCode <= busWrData[DIV_W-1:0];

      if (dataWr && !busy) done <= 1'b0;
      else if (lastFall)   done <= 1'b1;

      if (start) begin
        busy   <= 1'b1;
        halfQ  <= halfFor(divCode);
        cnt    <= '0;
        bitCnt <= '0;
        sckOut <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + CNT_W'(1);
        if (tick) sckOut <= !sckOut;
        if (stb.fall) bitCnt <= bitCnt + BIT_W'(1);
        if (lastFall) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_route_dp.sv
module spi_route_dp
  import spi_route_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        route,
  input  logic              sckIn,
  input  logic              portMiso,
  input  logic              perMiso,
  output logic [DATA_W-1:0] shiftQ,
  output logic              portSck,
  output logic              portMosi,
  output logic              perSck,
  output logic              perMosi
);
  logic rxBit, misoSel, mosiInt;

  assign mosiInt = shiftQ[DATA_W-1];

  always_comb begin
    portSck = 1'b0; portMosi = 1'b0;
    perSck  = 1'b0; perMosi  = 1'b0;
    misoSel = 1'b0;
    case (route)
      ROUTE_PORT: begin
        portSck = sckIn; portMosi = mosiInt; misoSel = portMiso;
      end
      ROUTE_PERIPH: begin
        perSck = sckIn; perMosi = mosiInt; misoSel = perMiso;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxBit  <= 1'b0;
    end else begin
      if (stb.load) shiftQ <= wrData;
      else if (stb.fall) shiftQ <= {shiftQ[DATA_W-2:0], rxBit};
      if (stb.rise) rxBit <= misoSel;
    end
  end
endmodule

// File: rtl/spi_route_master.sv
module spi_route_master
  import spi_route_pkg::*;
#(
  parameter logic [7:0] DATA_ADDR = 8'hB2,
  parameter logic [7:0] CTRL_ADDR = 8'hB3,
  parameter logic [7:0] DIV_ADDR  = 8'hB4,
  parameter int DIV_W   = 4,
  parameter int MAX_EXP = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       portSck,
  output logic       portMosi,
  input  logic       portMiso,
  output logic       perSck,
  output logic       perMosi,
  input  logic       perMiso
);
  localparam int DATA_W = 8;

  strobe_t          stb;
  logic             sckInt, busy, done;
  logic [1:0]       route;
  logic [DIV_W-1:0] divCode;
  logic [DATA_W-1:0] shiftQ;

  spi_route_ctrl #(
    .ADDR_W(8), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR), .DIV_ADDR(DIV_ADDR),
    .DATA_W(DATA_W), .DIV_W(DIV_W), .MAX_EXP(MAX_EXP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .stb(stb), .sckOut(sckInt), .busy(busy),
    .done(done), .route(route), .divCode(divCode)
  );

  spi_route_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .route(route),
    .sckIn(sckInt), .portMiso(portMiso), .perMiso(perMiso), .shiftQ(shiftQ),
    .portSck(portSck), .portMosi(portMosi), .perSck(perSck), .perMosi(perMosi)
  );

  always_comb begin
    busRdData = '0;
    if (busAddr == DATA_ADDR)      busRdData = shiftQ;
    else if (busAddr == CTRL_ADDR) busRdData = {done, busy, 4'b0000, route};
    else if (busAddr == DIV_ADDR)  busRdData = 8'(divCode);
  end
endmodule

// File: rtl/spi_route_checker.sv
module spi_route_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busAddr,
  input logic       busWrEn,
  input logic [1:0] route,
  input logic       busy,
  input logic       done,
  input logic       portSck,
  input logic       portMosi,
  input logic       perSck,
  input logic       perMosi
);
  localparam logic [7:0] DATA_ADDR = 8'hB2;

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (route == 2'b00 || route == 2'b11) |-> (!portSck && !perSck))
    else $error("p_off_quiet_r5");

  p_unsel_port_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (route == 2'b10) |-> (!portSck && !portMosi))
    else $error("p_unsel_port_low_r4");

  p_unsel_per_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (route == 2'b01) |-> (!perSck && !perMosi))
    else $error("p_unsel_per_low_r4");

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!portSck && !perSck))
    else $error("p_sck_idle_r3");

  p_mosi_hold_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(portSck) || $rose(perSck)) |-> ($stable(portMosi) && $stable(perMosi)))
    else $error("p_mosi_hold_rise_r3");

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done))
    else $error("p_busy_done_excl_r7");

  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DATA_ADDR && !busy) |=> !done)
    else $error("p_done_clear_r7");
endmodule

bind spi_route_master spi_route_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .route(route),
  .busy(busy), .done(done), .portSck(portSck), .portMosi(portMosi),
  .perSck(perSck), .perMosi(perMosi)
);

// File: tb/sim_spi_route_master.sv
module sim_spi_route_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'hB2, A_CTRL = 8'hB3, A_DIV = 8'hB4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] busAddr = 8'h00, busWrData = 8'h00;
  logic busWrEn = 1'b0;
  logic [7:0] busRdData;
  logic portSck, portMosi, portMiso, perSck, perMosi, perMiso;

  int testsRun = 0, testsFailed = 0;

  // bench slave model
  logic benchSel = 1'b0;          // 0: port endpoint, 1: peripheral endpoint
  logic [7:0] slvBuf = 8'h00, slvRx = 8'h00;
  logic unselSeen = 1'b0, anySckSeen = 1'b0;
  wire slvSck  = benchSel ? perSck : portSck;
  wire slvMosi = benchSel ? perMosi : portMosi;
  assign portMiso = benchSel ? 1'b1 : slvBuf[7];
  assign perMiso  = benchSel ? slvBuf[7] : 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_route_master u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .portSck(portSck),
    .portMosi(portMosi), .portMiso(portMiso), .perSck(perSck),
    .perMosi(perMosi), .perMiso(perMiso)
  );

  always @(posedge slvSck) slvRx <= {slvRx[6:0], slvMosi};
  always @(negedge slvSck) slvBuf <= {slvBuf[6:0], 1'b0};
  always @(posedge clk) begin
    if (benchSel ? (portSck || portMosi) : (perSck || perMosi)) unselSeen <= 1'b1;
    if (portSck || perSck) anySckSeen <= 1'b1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; #1 v = busRdData;
  endtask

  // runs an exchange; returns received byte, busy length
  task automatic exchange(input logic [7:0] tx, input logic [7:0] resp,
                          output logic [7:0] rx, output int cycles);
    logic [7:0] st;
    slvBuf = resp; slvRx = 8'h00; unselSeen = 1'b0;
    busWrite(A_DATA, tx);
    cycles = 0;
    busAddr = A_CTRL; #1;
    while (busRdData[6] && cycles < 5000) begin
      cycles++; @(negedge clk); #1;
    end
    busRead(A_DATA, rx);
    busRead(A_CTRL, st);
    check("R7", "done after exchange", int'(st[7]), 1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    busRead(A_DATA, v); check("R1", "data reset", v, 0);
    busRead(A_CTRL, v); check("R1", "ctrl reset", v, 0);
    busRead(A_DIV, v);  check("R1", "div reset", v, 0);
    check("R1", "lines low", {portSck, portMosi, perSck, perMosi}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    busWrite(A_DIV, 8'hFB); busRead(A_DIV, v); check("R2", "div readback", v, 8'h0B);
    busWrite(A_CTRL, 8'hFE); busRead(A_CTRL, v); check("R2", "ctrl readback", v, 8'h02);
    busWrite(A_DIV, 8'h00);
  endtask

  task automatic t_off();
    logic [7:0] v;
    foreach (v[i]) ;
    for (int k = 0; k < 2; k++) begin
      busWrite(A_CTRL, k == 0 ? 8'h00 : 8'h03);
      anySckSeen = 1'b0;
      busWrite(A_DATA, 8'h5A);
      repeat (40) @(negedge clk);
      check("R5", "no sck when off", int'(anySckSeen), 0);
      busRead(A_CTRL, v); check("R5", "busy stays low", int'(v[6]), 0);
      busRead(A_DATA, v); check("R5", "byte stored", v, 8'h5A);
    end
  endtask

  task automatic t_port();
    logic [7:0] rx; int cyc;
    benchSel = 1'b0;
    busWrite(A_CTRL, 8'h01);
    exchange(8'hA5, 8'h3C, rx, cyc);
    check("R3", "slave got MOSI", slvRx, 8'hA5);
    check("R3", "received byte", rx, 8'h3C);
    check("R6", "code0 length", cyc, 16);
    check("R4", "peripheral idle", int'(unselSeen), 0);
    exchange(8'h01, 8'h80, rx, cyc);
    check("R3", "slave got MOSI 2", slvRx, 8'h01);
    check("R3", "received byte 2", rx, 8'h80);
  endtask

  task automatic t_periph();
    logic [7:0] rx, v; int cyc;
    benchSel = 1'b1;
    busWrite(A_CTRL, 8'h02);
    exchange(8'hC3, 8'h00, rx, cyc);
    check("R4", "periph slave got MOSI", slvRx, 8'hC3);
    check("R4", "unselected MISO ignored", rx, 8'h00);
    check("R4", "port idle", int'(unselSeen), 0);
    busWrite(A_DATA, 8'h11);
    busRead(A_CTRL, v);
    check("R7", "done cleared by write", int'(v[7]), 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_div();
    logic [7:0] rx; int cyc;
    int codes[5] = '{1, 3, 6, 7, 15};
    int halves[5] = '{1, 4, 32, 32, 32};
    benchSel = 1'b0;
    busWrite(A_CTRL, 8'h01);
    for (int k = 0; k < 5; k++) begin
      busWrite(A_DIV, 8'(codes[k]));
      exchange(8'h69, 8'h96, rx, cyc);
      check("R6", $sformatf("length code %0d", codes[k]), cyc, 16 * halves[k]);
      check("R6", "byte at rate", rx, 8'h96);
    end
  endtask

  task automatic t_busy_write();
    logic [7:0] rx, v; int cyc;
    busWrite(A_DIV, 8'h02);
    slvBuf = 8'hE7; slvRx = 8'h00;
    busWrite(A_DATA, 8'h4D);
    repeat (10) @(negedge clk);
    busRead(A_CTRL, v); check("R7", "busy mid exchange", int'(v[6]), 1);
    busWrite(A_DATA, 8'hFF);
    cyc = 0; busAddr = A_CTRL; #1;
    while (busRdData[6] && cyc < 5000) begin cyc++; @(negedge clk); #1; end
    busRead(A_DATA, rx);
    check("R8", "sent bits unchanged", slvRx, 8'h4D);
    check("R8", "received unchanged", rx, 8'hE7);
  endtask

  task automatic t_div_change();
    int cyc;
    busWrite(A_DIV, 8'h06);
    slvBuf = 8'h00;
    busWrite(A_DATA, 8'h12);
    cyc = 2;
    busWrite(A_DIV, 8'h00);
    busAddr = A_CTRL; #1;
    while (busRdData[6] && cyc < 5000) begin cyc++; @(negedge clk); #1; end
    check("R9", "length kept after divider write", cyc, 512);
    begin
      logic [7:0] rx;
      exchange(8'h12, 8'h34, rx, cyc);
      check("R9", "new divider next exchange", cyc, 16);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_off();
    t_port();
    t_periph();
    t_div();
    t_busy_write();
    t_div_change();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule